// File: doc/BRIEF.md
# Gated M-P Clock-Enable Divider

This block divides a fast clock down to a slower rate. It does not make a new clock. Instead it produces `tick_o`, a strobe that is high for one cycle of `clk` once per output period. Logic downstream clocks on `clk` and qualifies its work with the strobe.

A single control word sets the period length. It holds five things:
- an M field, stored with a fixed offset;
- a P field, the exponent of a power-of-two divider;
- a gate bit;
- a timing-mode bit that doubles the period;
- optionally, a constant post-divider fixed at build time.

Software has two ways to change the word. It can replace the whole word. It can also hand over a divider value and a power-of-two value, and the block encodes them into the M and P ranges without touching anything else in the word.

The division is a cascade of counters: power-of-two stage, then M stage, then mode stage, then post stage. New divider settings are loaded only when every counter wraps at once, which is the end of an output period. As a result, a period is never cut short or stretched partway through.

Top module: `mp_clk_div`

## Requirements
- R1: Synchronous reset clears the control word to zero and holds `tick_o` low. Setting only the gate after reset gives the default period of 3 cycles: effective M 1, P exponent 0, post-divider 3.
- R2: With the gate on, `tick_o` is high for exactly one cycle per period. The period in `clk` cycles is 2^P × M_eff × (2 when mode is set, else 1) × POST_DIV. The POST_DIV factor applies only when the post stage is enabled.
- R3: M_eff is the value of the M field (bits [3:0]) plus M_OFFSET. A sum of zero is used as 1. With the defaults, M_eff spans 1 to 16.
- R4: A rate update (`upd_en`) does two things. It writes `upd_m` − M_OFFSET into bits [3:0], and it writes the base-2 logarithm of `upd_pdiv` into bits [17:16]. Every other bit of the word keeps its value. The word is visible on `rd_data` from the cycle after the write.
- R5: A full write (`wr_en`) loads `wr_data` into the whole word. When a full write and a rate update land in the same cycle, the word comes from `wr_data`, except that the M and P ranges come from the update.
- R6: When gate bit 31 is clear, `tick_o` stays low and all counters are cleared. When the gate is set again, the first tick follows one whole period.
- R7: Mode bit 30 set doubles the period that the other fields give.
- R8: A divider change written in the middle of a period does not affect that period, which finishes at its old length. The new length starts at the next period boundary. A change written together with the gate turning on takes effect at once.
- R9: When `upd_pdiv` is not a power of two, its highest set bit decides the P exponent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Full control-word write strobe |
| wr_data | input | 32 | Control word for a full write |
| upd_en | input | 1 | Rate update strobe (M and P ranges only) |
| upd_m | input | 5 | Desired effective M divider for a rate update |
| upd_pdiv | input | 4 | Desired power-of-two divider for a rate update |
| rd_data | output | 32 | Current control word |
| tick_o | output | 1 | One-cycle enable strobe at the divided rate |

## Verification
The bench goes after four corner cases.
- It changes the dividers partway through a period. A design that loaded them at once would show a first interval that is neither the old length nor the new one.
- It turns the gate off in the middle of a period and then back on. A design that kept stale counter state would give a short first interval, and one that did not honour the gate would produce stray ticks.
- It issues a full write and a rate update in the same cycle, and passes a divider that is not a power of two. Either one can show up as the wrong bits in the read-back word.
- On a second instance built with a zero offset, it writes an M field of zero. A design that did not force zero to one would stall there or count 2^M_WIDTH.

// File: rtl/mp_clk_div_pkg.sv
`timescale 1ns/1ps
package mp_clk_div_pkg;

  // Index of the highest set bit; zero input gives index zero.
  function automatic int unsigned msb_index(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Stored field plus offset, with a zero result promoted to one.
  function automatic int unsigned eff_divider(input int unsigned field,
                                              input int unsigned offset);
    int unsigned s;
    s = field + offset;
    return (s == 0) ? 1 : s;
  endfunction

  // Terminal count of a power-of-two stage with exponent e.
  function automatic int unsigned pow2_last(input int unsigned e);
    return (32'd1 << e) - 32'd1;
  endfunction

endpackage

// File: rtl/mp_div_stage.sv
`timescale 1ns/1ps
module mp_div_stage #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en_in,
  input  logic [CNT_W-1:0] last_val,
  output logic             en_out
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == last_val);
  assign en_out  = en_in && at_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en_in) begin
      cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mp_div_ctrl_reg.sv
`timescale 1ns/1ps
module mp_div_ctrl_reg
  import mp_clk_div_pkg::*;
#(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned M_SHIFT  = 0,
  parameter int unsigned M_WIDTH  = 4,
  parameter int unsigned M_OFFSET = 1,
  parameter int unsigned P_SHIFT  = 16,
  parameter int unsigned P_WIDTH  = 2,
  parameter int unsigned MODE_BIT = 30,
  parameter int unsigned MEFF_W   = 5,
  parameter int unsigned PDIV_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               upd_en,
  input  logic [MEFF_W-1:0]  upd_m,
  input  logic [PDIV_W-1:0]  upd_pdiv,
  output logic [REG_W-1:0]   ctrl_q,
  output logic [M_WIDTH-1:0] m_next,
  output logic [P_WIDTH-1:0] p_next,
  output logic               mode_next
);

  localparam logic [REG_W-1:0] M_ONES = REG_W'((64'd1 << M_WIDTH) - 64'd1);
  localparam logic [REG_W-1:0] P_ONES = REG_W'((64'd1 << P_WIDTH) - 64'd1);
  localparam logic [REG_W-1:0] M_MASK = M_ONES << M_SHIFT;
  localparam logic [REG_W-1:0] P_MASK = P_ONES << P_SHIFT;

  logic [REG_W-1:0]   base_word;
  logic [REG_W-1:0]   field_word;
  logic [REG_W-1:0]   ctrl_d;
  logic [M_WIDTH-1:0] m_code;
  logic [P_WIDTH-1:0] p_code;

  always_comb begin
    base_word  = wr_en ? wr_data : ctrl_q;
    m_code     = M_WIDTH'(upd_m - MEFF_W'(M_OFFSET));
    p_code     = P_WIDTH'(msb_index(32'(upd_pdiv)));
    field_word = (REG_W'(m_code) << M_SHIFT) | (REG_W'(p_code) << P_SHIFT);
    ctrl_d     = upd_en ? ((base_word & ~(M_MASK | P_MASK)) | field_word)
                        : base_word;
  end

  assign m_next    = ctrl_d[M_SHIFT +: M_WIDTH];
  assign p_next    = ctrl_d[P_SHIFT +: P_WIDTH];
  assign mode_next = ctrl_d[MODE_BIT];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/mp_div_cfg.sv
`timescale 1ns/1ps
module mp_div_cfg
  import mp_clk_div_pkg::*;
#(
  parameter int unsigned M_WIDTH  = 4,
  parameter int unsigned M_OFFSET = 1,
  parameter int unsigned P_WIDTH  = 2,
  parameter int unsigned MEFF_W   = 5,
  parameter int unsigned PDIV_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gate_on,
  input  logic               period_end,
  input  logic [M_WIDTH-1:0] m_field,
  input  logic [P_WIDTH-1:0] p_field,
  input  logic               mode_bit,
  output logic               cfg_load,
  output logic [MEFF_W-1:0]  m_last_q,
  output logic [PDIV_W-1:0]  pow_last_q,
  output logic               mode_last_q
);

  localparam logic [MEFF_W-1:0] M_LAST_RST = MEFF_W'(eff_divider(0, M_OFFSET) - 1);

  logic [MEFF_W-1:0] m_last_d;
  logic [PDIV_W-1:0] pow_last_d;

  assign cfg_load = !gate_on || period_end;

  always_comb begin
    m_last_d   = MEFF_W'(eff_divider(32'(m_field), M_OFFSET) - 1);
    pow_last_d = PDIV_W'(pow2_last(32'(p_field)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_last_q    <= M_LAST_RST;
      pow_last_q  <= '0;
      mode_last_q <= 1'b0;
    end else if (cfg_load) begin
      m_last_q    <= m_last_d;
      pow_last_q  <= pow_last_d;
      mode_last_q <= mode_bit;
    end
  end

endmodule

// File: rtl/mp_clk_div.sv
`timescale 1ns/1ps
module mp_clk_div #(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned M_SHIFT     = 0,
  parameter int unsigned M_WIDTH     = 4,
  parameter int unsigned M_OFFSET    = 1,
  parameter int unsigned P_SHIFT     = 16,
  parameter int unsigned P_WIDTH     = 2,
  parameter int unsigned GATE_BIT    = 31,
  parameter int unsigned MODE_BIT    = 30,
  parameter bit          POST_DIV_EN = 1'b1,
  parameter int unsigned POST_DIV    = 3,
  localparam int unsigned MEFF_W     = $clog2((1 << M_WIDTH) + M_OFFSET + 1),
  localparam int unsigned PEXP_MAX   = (1 << P_WIDTH) - 1,
  localparam int unsigned PDIV_W     = PEXP_MAX + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              upd_en,
  input  logic [MEFF_W-1:0] upd_m,
  input  logic [PDIV_W-1:0] upd_pdiv,
  output logic [REG_W-1:0]  rd_data,
  output logic              tick_o
);

  localparam int unsigned POST_W = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;

  logic [REG_W-1:0]   ctrl_q;
  logic [M_WIDTH-1:0] m_next;
  logic [P_WIDTH-1:0] p_next;
  logic               mode_next;
  logic               gate_on;
  logic               period_end;
  logic               cfg_load;
  logic [MEFF_W-1:0]  m_last_act;
  logic [PDIV_W-1:0]  pow_last_act;
  logic               mode_last_act;
  logic               en_pow, en_m, en_mode, en_post;

  mp_div_ctrl_reg #(
    .REG_W(REG_W), .M_SHIFT(M_SHIFT), .M_WIDTH(M_WIDTH), .M_OFFSET(M_OFFSET),
    .P_SHIFT(P_SHIFT), .P_WIDTH(P_WIDTH), .MODE_BIT(MODE_BIT),
    .MEFF_W(MEFF_W), .PDIV_W(PDIV_W)
  ) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .upd_en(upd_en), .upd_m(upd_m), .upd_pdiv(upd_pdiv),
    .ctrl_q(ctrl_q), .m_next(m_next), .p_next(p_next), .mode_next(mode_next)
  );

  assign gate_on = ctrl_q[GATE_BIT];
  assign rd_data = ctrl_q;

  mp_div_cfg #(
    .M_WIDTH(M_WIDTH), .M_OFFSET(M_OFFSET), .P_WIDTH(P_WIDTH),
    .MEFF_W(MEFF_W), .PDIV_W(PDIV_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .gate_on(gate_on), .period_end(period_end),
    .m_field(m_next), .p_field(p_next), .mode_bit(mode_next),
    .cfg_load(cfg_load), .m_last_q(m_last_act), .pow_last_q(pow_last_act),
    .mode_last_q(mode_last_act)
  );

  // Cascade: power-of-two, then M, then mode, then optional post stage.
  mp_div_stage #(.CNT_W(PDIV_W)) u_pow (
    .clk(clk), .rst(rst), .clr(!gate_on), .en_in(gate_on),
    .last_val(pow_last_act), .en_out(en_pow)
  );

  mp_div_stage #(.CNT_W(MEFF_W)) u_mdiv (
    .clk(clk), .rst(rst), .clr(!gate_on), .en_in(en_pow),
    .last_val(m_last_act), .en_out(en_m)
  );

  mp_div_stage #(.CNT_W(1)) u_mode (
    .clk(clk), .rst(rst), .clr(!gate_on), .en_in(en_m),
    .last_val(mode_last_act), .en_out(en_mode)
  );

  generate
    if (POST_DIV_EN && (POST_DIV > 1)) begin : g_post
      mp_div_stage #(.CNT_W(POST_W)) u_post (
        .clk(clk), .rst(rst), .clr(!gate_on), .en_in(en_mode),
        .last_val(POST_W'(POST_DIV - 1)), .en_out(en_post)
      );
    end else begin : g_no_post
      assign en_post = en_mode;
    end
  endgenerate

  assign period_end = en_post;
  assign tick_o     = period_end;

endmodule

// File: rtl/mp_clk_div_chk.sv
`timescale 1ns/1ps
module mp_clk_div_chk #(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned M_SHIFT  = 0,
  parameter int unsigned M_WIDTH  = 4,
  parameter int unsigned P_SHIFT  = 16,
  parameter int unsigned P_WIDTH  = 2,
  parameter int unsigned GATE_BIT = 31,
  parameter int unsigned MEFF_W   = 5,
  parameter int unsigned PDIV_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              upd_en,
  input logic [PDIV_W-1:0] upd_pdiv,
  input logic [REG_W-1:0]  rd_data,
  input logic              tick_o,
  input logic [MEFF_W-1:0] m_last_act,
  input logic [PDIV_W-1:0] pow_last_act,
  input logic              mode_last_act
);

  localparam logic [REG_W-1:0] FIELD_MASK =
    (REG_W'((64'd1 << M_WIDTH) - 64'd1) << M_SHIFT) |
    (REG_W'((64'd1 << P_WIDTH) - 64'd1) << P_SHIFT);
  localparam logic [P_WIDTH-1:0] PEXP_TOP = '1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !tick_o)); // R1

  AST_GATE_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !rd_data[GATE_BIT] |-> !tick_o); // R6

  AST_UPD_FIELDS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !wr_en) |=> ((rd_data & ~FIELD_MASK) == ($past(rd_data) & ~FIELD_MASK))); // R4

  AST_PEXP_UNITY: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_pdiv == PDIV_W'(1)) |=> (rd_data[P_SHIFT +: P_WIDTH] == '0)); // R4

  AST_PEXP_TOPBIT: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_pdiv[PDIV_W-1] && upd_pdiv != '0) |=> (rd_data[P_SHIFT +: P_WIDTH] == PEXP_TOP)); // R9

  AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    (rd_data[GATE_BIT] && !tick_o) |=>
      ($stable(m_last_act) && $stable(pow_last_act) && $stable(mode_last_act))); // R8

endmodule

bind mp_clk_div mp_clk_div_chk #(
  .REG_W(REG_W), .M_SHIFT(M_SHIFT), .M_WIDTH(M_WIDTH), .P_SHIFT(P_SHIFT),
  .P_WIDTH(P_WIDTH), .GATE_BIT(GATE_BIT), .MEFF_W(MEFF_W), .PDIV_W(PDIV_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .upd_en(upd_en), .upd_pdiv(upd_pdiv),
  .rd_data(rd_data), .tick_o(tick_o), .m_last_act(m_last_act),
  .pow_last_act(pow_last_act), .mode_last_act(mode_last_act)
);

// File: tb/mp_clk_div_bench.sv
`timescale 1ns/1ps
module mp_clk_div_bench;

  localparam logic [31:0] GATE = 32'h8000_0000;
  localparam logic [31:0] MODE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, upd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  upd_m = '0;
  logic [3:0]  upd_pdiv = '0;
  logic [31:0] rd_data;
  logic        tick_o;

  logic        b_wr_en = 1'b0;
  logic [31:0] b_wr_data = '0;
  logic [31:0] b_rd_data;
  logic        b_tick;

  int n_tests = 0;
  int n_fail  = 0;
  int cnt     = 0;
  int    exp_q[$];
  string tag_q[$];
  event  popped;

  always #2.5 clk = ~clk;

  mp_clk_div u_mp_clk_div (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .upd_en(upd_en),
    .upd_m(upd_m), .upd_pdiv(upd_pdiv), .rd_data(rd_data), .tick_o(tick_o)
  );

  mp_clk_div #(.M_OFFSET(0), .POST_DIV_EN(1'b0)) u_mp_clk_div_z (
    .clk(clk), .rst(rst), .wr_en(b_wr_en), .wr_data(b_wr_data), .upd_en(1'b0),
    .upd_m(5'd0), .upd_pdiv(4'd0), .rd_data(b_rd_data), .tick_o(b_tick)
  );

  function automatic int period(int mfield, int off, int pexp, bit mode, int post);
    int eff;
    eff = mfield + off;
    if (eff == 0) eff = 1;
    return eff * (1 << pexp) * (mode ? 2 : 1) * post;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push(input int n, input int per, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(per);
      tag_q.push_back(req);
    end
  endtask

  // Monitor: measures intervals between ticks while the gate is on.
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_data[31]) begin
        cnt++;
        if (tick_o) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected tick, interval", cnt, 0);
          end else begin
            automatic int    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(cnt == e, t, "tick interval", cnt, e);
          end
          cnt = 0;
          ->popped;
        end
      end else begin
        cnt = 0;
        if (tick_o) check(1'b0, "R6", "tick while gated", 1, 0);
      end
    end
  end

  task automatic wait_drain();
    while (exp_q.size() != 0) @(popped);
  endtask

  task automatic full_write(input logic [31:0] d, input logic [31:0] expv, input string req);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data == expv, req, "control word", rd_data, expv);
  endtask

  task automatic rate_update(input int m, input int pd, input logic [31:0] expv, input string req);
    upd_en = 1'b1; upd_m = 5'(m); upd_pdiv = 4'(pd);
    @(negedge clk);
    upd_en = 1'b0;
    check(rd_data == expv, req, "control word", rd_data, expv);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 32'h0, "R1", "reset word", rd_data, 0);
    check(tick_o == 1'b0, "R1", "reset tick", tick_o, 0);

    // R1 default period after a gate-only write
    push(2, period(0, 1, 0, 0, 3), "R1");
    full_write(GATE, GATE, "R1");
    wait_drain();

    // R2 mid-period full write: old period completes (R8)
    @(negedge clk);
    push(1, 3, "R8");
    push(3, period(2, 1, 1, 0, 3), "R2");
    full_write(GATE | 32'd2 | (32'd1 << 16), GATE | 32'd2 | (32'd1 << 16), "R2");
    wait_drain();

    // R4 rate update of M and P ranges
    @(negedge clk);
    push(1, 18, "R8");
    push(2, period(4, 1, 2, 0, 3), "R4");
    rate_update(5, 4, GATE | 32'd4 | (32'd2 << 16), "R4");
    wait_drain();

    // R7 mode doubles period
    @(negedge clk);
    push(1, 60, "R8");
    push(2, period(4, 1, 2, 1, 3), "R7");
    full_write(GATE | MODE | 32'd4 | (32'd2 << 16), GATE | MODE | 32'd4 | (32'd2 << 16), "R7");
    wait_drain();

    // R9 non-power-of-two divider uses highest set bit; R3 field zero + offset
    @(negedge clk);
    push(1, 120, "R8");
    push(2, period(0, 1, 2, 1, 3), "R9");
    rate_update(1, 6, GATE | MODE | (32'd2 << 16), "R9");
    wait_drain();

    // R6 gate off mid-period, stay silent, then full first period on re-enable
    @(negedge clk);
    full_write(MODE | (32'd2 << 16), MODE | (32'd2 << 16), "R6");
    repeat (40) @(negedge clk);
    check(tick_o == 1'b0, "R6", "tick after gate off", tick_o, 0);
    push(3, 24, "R6");
    full_write(GATE | MODE | (32'd2 << 16), GATE | MODE | (32'd2 << 16), "R6");
    wait_drain();

    // R5 full write and rate update in the same cycle
    @(negedge clk);
    push(1, 24, "R8");
    push(3, period(1, 1, 0, 0, 3), "R5");
    wr_en = 1'b1; wr_data = GATE | 32'h100 | 32'hF | (32'd3 << 16);
    upd_en = 1'b1; upd_m = 5'd2; upd_pdiv = 4'd1;
    @(negedge clk);
    wr_en = 1'b0; upd_en = 1'b0;
    check(rd_data == (GATE | 32'h100 | 32'd1), "R5", "merged word", rd_data, GATE | 32'h100 | 32'd1);
    wait_drain();

    // R3 largest M and P, other bits kept (R4)
    @(negedge clk);
    push(1, 6, "R8");
    push(2, period(15, 1, 3, 0, 3), "R3");
    rate_update(16, 8, GATE | 32'h100 | 32'hF | (32'd3 << 16), "R4");
    wait_drain();

    // R3 zero-offset instance: M field 0 forced to 1, tick every cycle
    b_wr_en = 1'b1; b_wr_data = GATE;
    @(negedge clk);
    b_wr_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(b_tick == 1'b1, "R3", "zero M continuous tick", b_tick, 1);
      @(negedge clk);
    end
    // R3 zero-offset instance: M field 3 gives period 3
    b_wr_en = 1'b1; b_wr_data = GATE | 32'd3;
    @(negedge clk);
    b_wr_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      automatic logic e = (i % 3 == 2);
      check(b_tick == e, "R3", "offset-zero M=3 pattern", b_tick, e);
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired, cycles", 100000, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule